// File: doc/BRIEF.md
# 8-bit Flag ALU with Status Register

This block is the non-arithmetic half of a small 8-bit processor's execute stage. Each cycle it receives a 5-bit operation code and an 8-bit operand, together with the accumulator, X and Y values. From these it computes an 8-bit result and a proposed next value of the processor status byte, both combinationally.

It covers:
- loads and register transfers;
- increment and decrement;
- shifts and rotates through carry;
- the three compares;
- the bit test;
- setting and clearing individual flags;
- forming the byte that a status push writes;
- absorbing a byte that a status pull reads.

Carry-based add and subtract, decimal arithmetic, operand fetch and memory access are handled elsewhere.

The status register lives inside the block. It takes the proposed value on a rising clock edge when `status_we` is high and otherwise holds. Bits 5 and 4 of the register are set by reset and never change afterwards, because a pull keeps them.

Status bit positions are: C = bit 0, Z = bit 1, I = bit 2, D = bit 3, B = bit 4, bit 5 unused, V = bit 6, N = bit 7.

Top module: `flag_alu`

## Requirements
- R1: A synchronous active-high `rst` sets `status` to 0x34 on the next rising edge.
- R2: On a rising edge with `status_we` high, `status` takes the value `status_next` had before the edge. With `status_we` low, `status` is unchanged.
- R3: The load and transfer codes are 0 (operand), 1 (acc), 2 (X) and 3 (Y). Each gives `result` equal to that source, sets Z (bit 1) when the result is zero and copies result bit 7 into N (bit 7). All other status bits are unchanged.
- R4: The increment and decrement codes are 4/5 (operand), 6/7 (X) and 8/9 (Y), with the even code adding 1 and the odd code subtracting 1. The result wraps modulo 256, Z and N follow the result, and the other bits are unchanged.
- R5: Code 10 shifts the operand left with a 0 entering bit 0, and operand bit 7 goes to C. Code 11 shifts it right with a 0 entering bit 7, and operand bit 0 goes to C. Z and N follow the result.
- R6: Code 12 rotates left, moving the old C into bit 0 and operand bit 7 into C. Code 13 rotates right, moving the old C into bit 7 and operand bit 0 into C. Z and N follow the result.
- R7: Codes 14, 15 and 16 compare acc, X and Y respectively against the operand. C is set when the register is unsigned greater than or equal to the operand. `result` is register minus operand modulo 256, and Z and N follow it.
- R8: Code 17 is the bit test. Z is set when (acc AND operand) is zero, V takes operand bit 6 and N takes operand bit 7. `result` equals acc, and C, I and D are unchanged.
- R9: Flag codes: 18 clears C (bit 0), 19 sets C, 20 clears I (bit 2), 21 sets I, 22 clears D (bit 3), 23 sets D, 24 clears V (bit 6). Each changes only its target bit, and `result` is 0.
- R10: `push_byte` always equals `status` with bits 5 and 4 forced to 1. Code 26 also returns that byte on `result` and leaves the status unchanged.
- R11: Code 25 (pull) gives `status_next` equal to `pull_byte` bits 7, 6 and 3..0, with bits 5 and 4 kept from the current `status`. `result` is 0.
- R12: Codes 27 to 31 give `result` 0 and leave `status_next` equal to `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 5 | Operation code |
| operand | input | 8 | Memory or immediate operand |
| acc | input | 8 | Accumulator value |
| xval | input | 8 | X register value |
| yval | input | 8 | Y register value |
| pull_byte | input | 8 | Byte read by a status pull |
| status_we | input | 1 | Status register write enable |
| result | output | 8 | Operation result |
| status_next | output | 8 | Proposed next status byte |
| status | output | 8 | Current status register |
| push_byte | output | 8 | Status byte for a push |

## Verification
The only internal state is the status byte, so a wrong register value appears at once on `status` and `push_byte`. It shows up one operation later through the carry-in of rotates and through every flag that an operation leaves untouched. A corrupted bit 4 or 5 is seen on `status` after the first pull. The bench therefore preloads eight distinct status patterns and sweeps every code over all 256 operands. It checks flags that should be kept as closely as flags that should change, and it follows each registered write with a held cycle.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter logic [7:0] RESET_STATUS = 8'h34
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] op,
  input  logic [7:0] operand,
  input  logic [7:0] acc,
  input  logic [7:0] xval,
  input  logic [7:0] yval,
  input  logic [7:0] pull_byte,
  input  logic       status_we,
  output logic [7:0] result,
  output logic [7:0] status_next,
  output logic [7:0] status,
  output logic [7:0] push_byte
);
  localparam int FC = 0, FZ = 1, FI = 2, FD = 3, FV = 6, FN = 7;
  localparam logic [7:0] KEEP_MASK = 8'h30;

  localparam logic [4:0] OP_LOAD = 5'd0,  OP_XA   = 5'd1,  OP_XX   = 5'd2,  OP_XY   = 5'd3;
  localparam logic [4:0] OP_INCM = 5'd4,  OP_DECM = 5'd5,  OP_INCX = 5'd6,  OP_DECX = 5'd7;
  localparam logic [4:0] OP_INCY = 5'd8,  OP_DECY = 5'd9,  OP_SHL  = 5'd10, OP_SHR  = 5'd11;
  localparam logic [4:0] OP_ROTL = 5'd12, OP_ROTR = 5'd13, OP_CMPA = 5'd14, OP_CMPX = 5'd15;
  localparam logic [4:0] OP_CMPY = 5'd16, OP_TEST = 5'd17, OP_CLRC = 5'd18, OP_SETC = 5'd19;
  localparam logic [4:0] OP_CLRI = 5'd20, OP_SETI = 5'd21, OP_CLRD = 5'd22, OP_SETD = 5'd23;
  localparam logic [4:0] OP_CLRV = 5'd24, OP_PULL = 5'd25, OP_PUSH = 5'd26;

  logic [7:0] res;
  logic [7:0] nxt;
  logic       upd_nz;

  assign push_byte = status | KEEP_MASK;

  always_comb begin
    res    = 8'h00;
    nxt    = status;
    upd_nz = 1'b0;
    case (op)
      OP_LOAD: begin res = operand; upd_nz = 1'b1; end
      OP_XA:   begin res = acc;     upd_nz = 1'b1; end
      OP_XX:   begin res = xval;    upd_nz = 1'b1; end
      OP_XY:   begin res = yval;    upd_nz = 1'b1; end
      OP_INCM: begin res = operand + 8'd1; upd_nz = 1'b1; end
      OP_DECM: begin res = operand - 8'd1; upd_nz = 1'b1; end
      OP_INCX: begin res = xval + 8'd1;    upd_nz = 1'b1; end
      OP_DECX: begin res = xval - 8'd1;    upd_nz = 1'b1; end
      OP_INCY: begin res = yval + 8'd1;    upd_nz = 1'b1; end
      OP_DECY: begin res = yval - 8'd1;    upd_nz = 1'b1; end
      OP_SHL: begin
        res = {operand[6:0], 1'b0};
        nxt[FC] = operand[7];
        upd_nz = 1'b1;
      end
      OP_SHR: begin
        res = {1'b0, operand[7:1]};
        nxt[FC] = operand[0];
        upd_nz = 1'b1;
      end
      OP_ROTL: begin
        res = {operand[6:0], status[FC]};
        nxt[FC] = operand[7];
        upd_nz = 1'b1;
      end
      OP_ROTR: begin
        res = {status[FC], operand[7:1]};
        nxt[FC] = operand[0];
        upd_nz = 1'b1;
      end
      OP_CMPA: begin res = acc - operand;  nxt[FC] = acc >= operand;  upd_nz = 1'b1; end
      OP_CMPX: begin res = xval - operand; nxt[FC] = xval >= operand; upd_nz = 1'b1; end
      OP_CMPY: begin res = yval - operand; nxt[FC] = yval >= operand; upd_nz = 1'b1; end
      OP_TEST: begin
        res = acc;
        nxt[FZ] = (acc & operand) == 8'h00;
        nxt[FV] = operand[6];
        nxt[FN] = operand[7];
      end
      OP_CLRC: nxt[FC] = 1'b0;
      OP_SETC: nxt[FC] = 1'b1;
      OP_CLRI: nxt[FI] = 1'b0;
      OP_SETI: nxt[FI] = 1'b1;
      OP_CLRD: nxt[FD] = 1'b0;
      OP_SETD: nxt[FD] = 1'b1;
      OP_CLRV: nxt[FV] = 1'b0;
      OP_PULL: nxt = (pull_byte & ~KEEP_MASK) | (status & KEEP_MASK);
      OP_PUSH: res = push_byte;
      default: ;
    endcase
    if (upd_nz) begin
      nxt[FZ] = res == 8'h00;
      nxt[FN] = res[7];
    end
  end

  assign result      = res;
  assign status_next = nxt;

  always_ff @(posedge clk) begin
    if (rst)            status <= RESET_STATUS;
    else if (status_we) status <= status_next;
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] op,
  input logic [7:0] operand,
  input logic [7:0] acc,
  input logic       status_we,
  input logic [7:0] result,
  input logic [7:0] status_next,
  input logic [7:0] status,
  input logic [7:0] push_byte
);
  a_r1_reset_value: assert property (@(posedge clk) rst |=> status == 8'h34);

  a_r2_write: assert property (@(posedge clk) disable iff (rst)
    status_we |=> status == $past(status_next));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !status_we |=> status == $past(status));

  a_r8_bit_test: assert property (@(posedge clk) disable iff (rst)
    op == 5'd17 |-> status_next[7:6] == operand[7:6] && result == acc
                    && status_next[3:2] == status[3:2] && status_next[0] == status[0]);

  a_r9_single_bit: assert property (@(posedge clk) disable iff (rst)
    (op >= 5'd18 && op <= 5'd24) |-> $countones(status_next ^ status) <= 1 && result == 8'h00);

  a_r10_push_bits: assert property (@(posedge clk) disable iff (rst)
    push_byte[5:4] == 2'b11 && push_byte[7:6] == status[7:6] && push_byte[3:0] == status[3:0]);

  a_r11_keep_45: assert property (@(posedge clk) disable iff (rst)
    status[5:4] == 2'b11);

  a_r11_pull_keep: assert property (@(posedge clk) disable iff (rst)
    op == 5'd25 |-> status_next[5:4] == status[5:4]);

  a_r12_unused: assert property (@(posedge clk) disable iff (rst)
    op >= 5'd27 |-> status_next == status && result == 8'h00);
endmodule

bind flag_alu flag_alu_chk u_chk (.*);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op = '0;
  logic [7:0] operand = '0, acc = '0, xval = '0, yval = '0, pull_byte = '0;
  logic       status_we = 1'b0;
  logic [7:0] result, status_next, status, push_byte;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst(rst), .op(op), .operand(operand), .acc(acc), .xval(xval),
    .yval(yval), .pull_byte(pull_byte), .status_we(status_we), .result(result),
    .status_next(status_next), .status(status), .push_byte(push_byte)
  );

  function automatic int setb(int v, int b, int val);
    int m = 1 << b;
    return val != 0 ? (v | m) : (v & (255 - m));
  endfunction

  function automatic string tag_of(int o);
    if (o <= 3)  return "R3";
    if (o <= 9)  return "R4";
    if (o <= 11) return "R5";
    if (o <= 13) return "R6";
    if (o <= 16) return "R7";
    if (o == 17) return "R8";
    if (o <= 24) return "R9";
    if (o == 25) return "R11";
    if (o == 26) return "R10";
    return "R12";
  endfunction

  task automatic model(input int o, input int a, input int x, input int y, input int m,
                       input int s, input int p, output int r, output int ns);
    int src;
    int c;
    r = 0; ns = s; c = s % 2;
    case (o)
      0: r = m;
      1: r = a;
      2: r = x;
      3: r = y;
      4, 6, 8: begin src = (o == 4) ? m : (o == 6) ? x : y; r = (src + 1) % 256; end
      5, 7, 9: begin src = (o == 5) ? m : (o == 7) ? x : y; r = (src + 255) % 256; end
      10: begin r = (m * 2) % 256;       ns = setb(ns, 0, m / 128); end
      11: begin r = m / 2;               ns = setb(ns, 0, m % 2); end
      12: begin r = (m * 2) % 256 + c;   ns = setb(ns, 0, m / 128); end
      13: begin r = m / 2 + 128 * c;     ns = setb(ns, 0, m % 2); end
      14, 15, 16: begin
        src = (o == 14) ? a : (o == 15) ? x : y;
        r = (src - m + 256) % 256;
        ns = setb(ns, 0, src >= m ? 1 : 0);
      end
      17: begin
        r = a;
        ns = setb(ns, 1, (a & m) == 0 ? 1 : 0);
        ns = setb(ns, 6, (m / 64) % 2);
        ns = setb(ns, 7, m / 128);
      end
      18: ns = setb(ns, 0, 0);
      19: ns = setb(ns, 0, 1);
      20: ns = setb(ns, 2, 0);
      21: ns = setb(ns, 2, 1);
      22: ns = setb(ns, 3, 0);
      23: ns = setb(ns, 3, 1);
      24: ns = setb(ns, 6, 0);
      25: ns = (p & 8'hCF) | (s & 8'h30);
      26: r = s | 8'h30;
      default: ;
    endcase
    if (o <= 16) begin
      ns = setb(ns, 1, r == 0 ? 1 : 0);
      ns = setb(ns, 7, r / 128);
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pat(int i);
    case (i)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h01; 3: return 8'h80;
      4: return 8'h40; 5: return 8'h0C; 6: return 8'hC3; default: return 8'h5A;
    endcase
  endfunction

  task automatic load_status(input int p);
    @(negedge clk);
    op = 5'd25; pull_byte = 8'(p); status_we = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    status_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int r, ns, s;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset status", int'(status), 8'h34);
    chk("R10", "push after reset", int'(push_byte), 8'h34);
    @(negedge clk);
    rst = 1'b0;

    // combinational sweep over preloaded status patterns
    for (int si = 0; si < 8; si++) begin
      load_status(pat(si));
      s = (pat(si) & 8'hCF) | 8'h30;
      chk("R11", "loaded status", int'(status), s);
      chk("R10", "push byte", int'(push_byte), s | 8'h30);
      for (int o = 0; o < 32; o++) begin
        for (int m = 0; m < 256; m++) begin
          int a, x, y, p;
          a = (m + si * 40) % 256;
          x = (m + 256 - si * 3) % 256;
          y = (m * 5 + si) % 256;
          p = m ^ 8'h5A;
          op = 5'(o); operand = 8'(m); acc = 8'(a); xval = 8'(x); yval = 8'(y);
          pull_byte = 8'(p);
          #1;
          model(o, a, x, y, m, s, p, r, ns);
          chk(tag_of(o), "result/status_next", {16'd0, result, status_next}, (r << 8) | ns);
        end
      end
    end

    // registered path: write with enable, then hold without it
    for (int o = 0; o < 32; o++) begin
      for (int k = 0; k < 8; k++) begin
        int m, a, hold;
        m = (k * 73 + o * 11) % 256;
        a = (m + k * 29) % 256;
        load_status(pat(k));
        s = (pat(k) & 8'hCF) | 8'h30;
        op = 5'(o); operand = 8'(m); acc = 8'(a); xval = 8'(m ^ 3); yval = 8'(a ^ 8'h81);
        pull_byte = 8'(pat(7 - k));
        status_we = 1'b1;
        model(o, a, m ^ 3, a ^ 8'h81, m, s, pat(7 - k), r, ns);
        @(posedge clk); #1;
        chk("R2", "status after write", int'(status), ns);
        hold = ns;
        @(negedge clk);
        status_we = 1'b0;
        op = 5'(19 + (k % 2) * 3);
        @(posedge clk); #1;
        chk("R2", "status held", int'(status), hold);
        chk("R10", "push of held status", int'(push_byte), hold | 8'h30);
        @(negedge clk);
      end
    end

    // reset from a non-default state
    load_status(8'hCB);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "reset from loaded state", int'(status), 8'h34);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    finish_run();
  end
endmodule